// File: doc/BRIEF.md
# Volatile Sector Lock Controller

This block keeps track of which sectors of a multi-sector flash array may be programmed or erased. It watches word-write cycles on a plain bus (address, data, write enable) for three protection commands. One command locks the whole array. One unlocks a single sector and relocks every other one. One marks a run of sectors, starting at sector zero, as pinned. A pinned sector stays locked against any later unlock until power-on reset. None of this state survives reset: after reset every sector is writable.

A query port reports, without a clock edge, whether a given sector is currently writable. An operation port takes program or erase requests. A request is granted in the same cycle when its sector is writable. A rejected request sets a sticky error flag, and the next granted request clears it. The flash array, the erase and program engines and the pin timing of the bus lie outside the block.

Top module: `sector_lock_ctrl`

## Requirements
- R1: After reset every sector is writable, no sector is pinned, the decoder is idle and `lock_err` is 0.
- R2: A lock command is three enabled writes. The first has address low 12 bits 555h and data 0060h. The second has 2AAh and 0060h. The third has a valid sector address with address bit 6 = 0 and data 0060h. After the third write, every sector is locked.
- R3: An unlock command is the same sequence with address bit 6 = 1 in the third write. When the addressed sector is not pinned, it leaves exactly that sector writable and every other sector locked.
- R4: A pin command is four writes: 555h/0060h, then 2AAh/0060h, then sector address S with 0061h, then the same sector S with 0061h. It pins and locks every sector with index 0 up to S. Bit 6 plays no part in this command.
- R5: An unlock addressed to a pinned sector changes no lock state. Only reset clears a pin.
- R6: Any enabled write that does not match the next expected address/data pair returns the decoder to idle and changes no state. This includes a fourth pin write naming a different sector. Cycles with `wr_en` low are ignored.
- R7: `q_allow` is 1 exactly when sector `q_sect` is writable, combinationally. It is 0 for an index of `NUM_SECT` or above.
- R8: `op_grant` equals `op_req` AND (sector `op_sect` writable), in the same cycle.
- R9: `lock_err` becomes 1 on the edge after a rejected request and 0 on the edge after a granted request. Otherwise it holds its value.
- R10: The sector index is taken from the top `SECT_W` address bits. A command whose sector index is `NUM_SECT` or above is treated as a mismatch (R6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en | input | 1 | Bus write strobe, one write per enabled cycle |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 16 | Write data |
| q_sect | input | SECT_W | Sector to query |
| q_allow | output | 1 | Queried sector is writable |
| op_req | input | 1 | Program/erase request |
| op_sect | input | SECT_W | Target sector of the request |
| op_grant | output | 1 | Request accepted this cycle |
| lock_err | output | 1 | Sticky flag: last resolved request was rejected |

## Verification
The bench builds the block with `NUM_SECT = 6` and `ADDR_W = 16`. Because the array size is not a power of two, sector indices 6 and 7 can be encoded but do not exist, so the out-of-range rejection of R10 and the zero query answer of R7 can be exercised. With six sectors, every query check sweeps the whole array each time. The pin range can then be placed in the middle of the array, which shows that sectors above the addressed one stay free to unlock.

// File: rtl/seclk_pkg.sv
package seclk_pkg;

  typedef enum logic [1:0] {
    DS_IDLE   = 2'd0,
    DS_FIRST  = 2'd1,
    DS_SECOND = 2'd2,
    DS_PIN    = 2'd3
  } dec_state_t;

  localparam logic [11:0] CMD_ADDR_A = 12'h555;
  localparam logic [11:0] CMD_ADDR_B = 12'h2AA;
  localparam logic [15:0] CMD_PROT   = 16'h0060;
  localparam logic [15:0] CMD_PIN    = 16'h0061;
  localparam int          MODE_BIT   = 6;

  function automatic logic cycle_match(input logic [11:0] addr_lo,
                                       input logic [15:0] data,
                                       input logic [11:0] exp_addr,
                                       input logic [15:0] exp_data);
    return (addr_lo == exp_addr) && (data == exp_data);
  endfunction

endpackage

// File: rtl/seclk_cmd_decode.sv
module seclk_cmd_decode
  import seclk_pkg::*;
#(
  parameter int NUM_SECT = 16,
  parameter int ADDR_W   = 24,
  parameter int SECT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  output logic              ev_lock,
  output logic              ev_unlock,
  output logic              ev_pin,
  output logic [SECT_W-1:0] ev_sect
);

  dec_state_t        st, st_nxt;
  logic [SECT_W-1:0] held_sect;
  logic [SECT_W-1:0] cur_sect;
  logic              sect_ok;
  logic              hit_a, hit_b;
  logic              addr_unused;

  assign cur_sect    = wr_addr[ADDR_W-1 -: SECT_W];
  assign sect_ok     = ({1'b0, cur_sect} < (SECT_W+1)'(NUM_SECT));
  assign hit_a       = cycle_match(wr_addr[11:0], wr_data, CMD_ADDR_A, CMD_PROT);
  assign hit_b       = cycle_match(wr_addr[11:0], wr_data, CMD_ADDR_B, CMD_PROT);
  assign ev_sect     = cur_sect;
  assign addr_unused = ^wr_addr;

  always_comb begin
    st_nxt    = st;
    ev_lock   = 1'b0;
    ev_unlock = 1'b0;
    ev_pin    = 1'b0;
    if (wr_en) begin
      st_nxt = DS_IDLE;
      unique case (st)
        DS_IDLE:   if (hit_a) st_nxt = DS_FIRST;
        DS_FIRST:  if (hit_b) st_nxt = DS_SECOND;
        DS_SECOND: begin
          if (sect_ok && wr_data == CMD_PROT) begin
            ev_unlock = wr_addr[MODE_BIT];
            ev_lock   = ~wr_addr[MODE_BIT];
          end else if (sect_ok && wr_data == CMD_PIN) begin
            st_nxt = DS_PIN;
          end
        end
        DS_PIN: begin
          if (sect_ok && wr_data == CMD_PIN && cur_sect == held_sect)
            ev_pin = 1'b1;
        end
        default: st_nxt = DS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= DS_IDLE;
      held_sect <= '0;
    end else begin
      st <= st_nxt;
      if (wr_en && st == DS_SECOND) held_sect <= cur_sect;
    end
  end

endmodule

// File: rtl/seclk_lock_array.sv
module seclk_lock_array #(
  parameter int NUM_SECT = 16,
  parameter int SECT_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_lock,
  input  logic                ev_unlock,
  input  logic                ev_pin,
  input  logic [SECT_W-1:0]   ev_sect,
  output logic [NUM_SECT-1:0] lk_vec,
  output logic [NUM_SECT-1:0] pin_vec
);

  function automatic logic [NUM_SECT-1:0] upto_mask(input logic [SECT_W-1:0] s);
    logic [NUM_SECT-1:0] m;
    for (int i = 0; i < NUM_SECT; i++) m[i] = (i <= int'(s));
    return m;
  endfunction

  function automatic logic [NUM_SECT-1:0] only_mask(input logic [SECT_W-1:0] s);
    logic [NUM_SECT-1:0] m;
    for (int i = 0; i < NUM_SECT; i++) m[i] = (i == int'(s));
    return m;
  endfunction

  logic target_pinned;

  always_comb begin
    target_pinned = 1'b0;
    for (int i = 0; i < NUM_SECT; i++)
      if (int'(ev_sect) == i) target_pinned = pin_vec[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_vec  <= '0;
      pin_vec <= '0;
    end else if (ev_lock) begin
      lk_vec <= '1;
    end else if (ev_unlock && !target_pinned) begin
      lk_vec <= ~only_mask(ev_sect);
    end else if (ev_pin) begin
      pin_vec <= pin_vec | upto_mask(ev_sect);
      lk_vec  <= lk_vec  | upto_mask(ev_sect);
    end
  end

endmodule

// File: rtl/seclk_op_guard.sv
module seclk_op_guard #(
  parameter int NUM_SECT = 16,
  parameter int SECT_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SECT-1:0] lk_vec,
  input  logic [SECT_W-1:0]   q_sect,
  input  logic                op_req,
  input  logic [SECT_W-1:0]   op_sect,
  output logic                q_allow,
  output logic                op_grant,
  output logic                lock_err
);

  function automatic logic writable(input logic [NUM_SECT-1:0] lk,
                                    input logic [SECT_W-1:0]   s);
    logic w;
    w = 1'b0;
    for (int i = 0; i < NUM_SECT; i++)
      if (int'(s) == i) w = ~lk[i];
    return w;
  endfunction

  assign q_allow  = writable(lk_vec, q_sect);
  assign op_grant = op_req & writable(lk_vec, op_sect);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lock_err <= 1'b0;
    else if (op_req) lock_err <= ~op_grant;
  end

endmodule

// File: rtl/sector_lock_ctrl.sv
module sector_lock_ctrl #(
  parameter int NUM_SECT = 16,
  parameter int ADDR_W   = 24,
  parameter int SECT_W   = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [SECT_W-1:0] q_sect,
  output logic              q_allow,
  input  logic              op_req,
  input  logic [SECT_W-1:0] op_sect,
  output logic              op_grant,
  output logic              lock_err
);

  logic                ev_lock, ev_unlock, ev_pin;
  logic [SECT_W-1:0]   ev_sect;
  logic [NUM_SECT-1:0] lk_vec, pin_vec;

  seclk_cmd_decode #(.NUM_SECT(NUM_SECT), .ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ev_lock(ev_lock), .ev_unlock(ev_unlock), .ev_pin(ev_pin), .ev_sect(ev_sect)
  );

  seclk_lock_array #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .ev_lock(ev_lock), .ev_unlock(ev_unlock),
    .ev_pin(ev_pin), .ev_sect(ev_sect), .lk_vec(lk_vec), .pin_vec(pin_vec)
  );

  seclk_op_guard #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W)) u_grd (
    .clk(clk), .rst_n(rst_n), .lk_vec(lk_vec), .q_sect(q_sect), .op_req(op_req),
    .op_sect(op_sect), .q_allow(q_allow), .op_grant(op_grant), .lock_err(lock_err)
  );

endmodule

// File: rtl/seclk_checker.sv
module seclk_checker #(
  parameter int NUM_SECT = 16,
  parameter int SECT_W   = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic                ev_lock,
  input logic                ev_unlock,
  input logic                ev_pin,
  input logic [SECT_W-1:0]   ev_sect,
  input logic [NUM_SECT-1:0] lk_vec,
  input logic [NUM_SECT-1:0] pin_vec,
  input logic                op_req,
  input logic                op_grant,
  input logic                lock_err
);

  logic sel_pinned;
  always_comb begin
    sel_pinned = 1'b0;
    for (int i = 0; i < NUM_SECT; i++)
      if (int'(ev_sect) == i) sel_pinned = pin_vec[i];
  end

  p_lock_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lock |=> (&lk_vec));

  p_single_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_unlock && !sel_pinned) |=> ($countones(~lk_vec) == 1));

  p_pinned_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_vec & ~lk_vec) == '0);

  p_pin_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pin_vec & $past(pin_vec)) == $past(pin_vec)));

  p_pinned_unlock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_unlock && sel_pinned) |=> $stable(lk_vec));

  p_idle_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(lk_vec) && $stable(pin_vec)));

  p_one_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_lock, ev_unlock, ev_pin}));

  p_err_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_req && !op_grant) |=> lock_err);

  p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_grant |=> !lock_err);

  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_req |=> $stable(lock_err));

endmodule

bind sector_lock_ctrl seclk_checker #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ev_lock(ev_lock), .ev_unlock(ev_unlock),
  .ev_pin(ev_pin), .ev_sect(ev_sect), .lk_vec(lk_vec), .pin_vec(pin_vec),
  .op_req(op_req), .op_grant(op_grant), .lock_err(lock_err)
);

// File: tb/sim_sector_lock_ctrl.sv
`timescale 1ns/1ps
module sim_sector_lock_ctrl;
  localparam int NS = 6;
  localparam int AW = 16;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic [SW-1:0] q_sect = '0;
  logic          q_allow;
  logic          op_req = 1'b0;
  logic [SW-1:0] op_sect = '0;
  logic          op_grant;
  logic          lock_err;

  int n_run = 0;
  int n_fail = 0;
  logic [NS-1:0] exp_open;   // 1 = writable
  logic [NS-1:0] exp_pin;

  always #4 clk = ~clk;

  sector_lock_ctrl #(.NUM_SECT(NS), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .q_sect(q_sect), .q_allow(q_allow), .op_req(op_req), .op_sect(op_sect),
    .op_grant(op_grant), .lock_err(lock_err)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] sect_addr(input int s, input logic b6);
    logic [AW-1:0] a;
    a = '0;
    a[AW-1 -: SW] = SW'(s);
    a[6] = b6;
    return a;
  endfunction

  task automatic bus_wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cmd_lock();
    bus_wr(16'h0555, 16'h0060); bus_wr(16'h02AA, 16'h0060); bus_wr(sect_addr(0, 1'b0), 16'h0060);
    exp_open = '0;
  endtask

  task automatic cmd_unlock(input int s);
    bus_wr(16'h0555, 16'h0060); bus_wr(16'h02AA, 16'h0060); bus_wr(sect_addr(s, 1'b1), 16'h0060);
    if (s < NS && !exp_pin[s]) begin
      exp_open = '0;
      exp_open[s] = 1'b1;
    end
  endtask

  task automatic cmd_pin(input int s);
    bus_wr(16'h0555, 16'h0060); bus_wr(16'h02AA, 16'h0060);
    bus_wr(sect_addr(s, 1'b1), 16'h0061); bus_wr(sect_addr(s, 1'b0), 16'h0061);
    for (int i = 0; i <= s; i++) begin
      exp_pin[i] = 1'b1;
      exp_open[i] = 1'b0;
    end
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < NS; i++) begin
      q_sect = SW'(i);
      #1;
      check(req, q_allow, exp_open[i]);
    end
  endtask

  task automatic t_reset();
    exp_open = '1; exp_pin = '0;
    sweep("R1 reset all writable");
    check("R1 reset lock_err", lock_err, 1'b0);
    q_sect = 3'd6; #1; check("R7 query beyond array", q_allow, 1'b0);
    q_sect = 3'd7; #1; check("R7 query beyond array", q_allow, 1'b0);
  endtask

  task automatic t_lock_unlock();
    cmd_unlock(4);
    sweep("R3 unlock from open array");
    cmd_lock();
    sweep("R2 lock all");
    cmd_unlock(2);
    sweep("R3 unlock sector 2");
    cmd_unlock(5);
    sweep("R3 unlock moves to sector 5");
  endtask

  task automatic t_abort();
    bus_wr(16'h0555, 16'h0060); bus_wr(16'h02AA, 16'h0055); bus_wr(sect_addr(1, 1'b1), 16'h0060);
    sweep("R6 bad second data aborts");
    bus_wr(16'h0554, 16'h0060); bus_wr(16'h02AA, 16'h0060); bus_wr(sect_addr(0, 1'b0), 16'h0060);
    sweep("R6 bad first address aborts");
    bus_wr(16'h0555, 16'h0060); bus_wr(16'h0555, 16'h0060); bus_wr(16'h02AA, 16'h0060);
    bus_wr(sect_addr(3, 1'b1), 16'h0060);
    sweep("R6 repeated first cycle aborts");
    @(negedge clk);
    wr_addr = 16'h0555; wr_data = 16'h0060;
    @(negedge clk); wr_addr = 16'h02AA;
    @(negedge clk); wr_addr = sect_addr(0, 1'b0);
    @(negedge clk);
    sweep("R6 writes with wr_en low ignored");
  endtask

  task automatic t_range_sector();
    cmd_unlock(6);
    sweep("R10 sector index 6 rejected");
    cmd_unlock(7);
    sweep("R10 sector index 7 rejected");
  endtask

  task automatic t_ops();
    cmd_unlock(1);
    @(negedge clk);
    op_req = 1'b1; op_sect = 3'd3; #1;
    check("R8 grant on locked sector", op_grant, 1'b0);
    @(negedge clk); op_req = 1'b0;
    check("R9 error set after reject", lock_err, 1'b1);
    @(negedge clk); @(negedge clk);
    check("R9 error held while idle", lock_err, 1'b1);
    op_req = 1'b1; op_sect = 3'd1; #1;
    check("R8 grant on open sector", op_grant, 1'b1);
    @(negedge clk); op_req = 1'b0;
    check("R9 error cleared after grant", lock_err, 1'b0);
    op_req = 1'b1; op_sect = 3'd7; #1;
    check("R8 grant beyond array", op_grant, 1'b0);
    @(negedge clk); op_req = 1'b0;
    check("R9 error after out-of-array request", lock_err, 1'b1);
  endtask

  task automatic t_pin();
    bus_wr(16'h0555, 16'h0060); bus_wr(16'h02AA, 16'h0060);
    bus_wr(sect_addr(3, 1'b0), 16'h0061); bus_wr(sect_addr(4, 1'b0), 16'h0061);
    sweep("R6 pin with mismatched sector aborts");
    cmd_unlock(3);
    sweep("R6 sector 3 still unlockable");
    cmd_pin(2);
    sweep("R4 pin sectors 0..2");
    cmd_unlock(1);
    sweep("R5 unlock of pinned sector 1 ignored");
    cmd_unlock(0);
    sweep("R5 unlock of pinned sector 0 ignored");
    cmd_unlock(4);
    sweep("R4 sector above pin still unlockable");
    cmd_lock();
    cmd_unlock(2);
    sweep("R5 pinned sector stays locked after lock");
  endtask

  task automatic t_reset_clears();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    exp_open = '1; exp_pin = '0;
    sweep("R1 reset clears pins and locks");
    cmd_lock();
    cmd_unlock(0);
    sweep("R1 sector 0 unpinned after reset");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    exp_open = '1; exp_pin = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock_unlock();
    t_abort();
    t_range_sector();
    t_ops();
    t_pin();
    t_reset_clears();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule